// File: doc/BRIEF.md
# Linked Word/Byte Shift Unit

This block is a one-place shift stage for a 16-bit microprogrammed datapath. It accepts an A operand, the current extension register (XR) value, a carry-in, a negative status bit, a 4-bit shift code and a byte-mode flag. From these it forms a shifted result, an updated XR value and six condition flags: carry, overflow, zero, negative, positive and low-bit. The operations are a half-swap, a logical left shift, a logical right shift and an arithmetic right shift. Any of them can be open or closed (rotate), and single-length or double-length. In double-length mode, A and XR act as one 32-bit quantity with A as the upper word.

In byte mode only the low byte of A is operated on, and the high byte is copied to the result unchanged. Multi-place shifts are made by issuing the operation repeatedly from outside the block. The computed values are registered once, so every output reflects the inputs present at the previous rising clock edge. An active-low reset clears all outputs.

Top module: `lws_unit`

## Requirements
- R1: While `rst_n` is low, and on the first sample after reset is applied, `res_q`, `xr_q` and all six flags are 0.
- R2: Code bits 3:2 equal to 00 select a half-swap. In word mode the two bytes of A are exchanged. In byte mode the two nibbles of A's low byte are exchanged. `xr_q` always equals the XR input. Carry is the field top bit of A, and overflow is that bit XOR the bit below it.
- R3: Code bits 3:2 equal to 01 select a left shift by one. With code bit 0 = 0 (open), carry-in enters field bit 0. With code bit 0 = 1 (closed), the field's outgoing top bit enters bit 0. The carry flag is the outgoing top bit.
- R4: Code bits 3:2 equal to 10 select a logical right shift. With code bit 0 = 0, carry-in enters the field top bit. With code bit 0 = 1, A bit 0 enters the field top bit. The carry flag is A bit 0.
- R5: Code bits 3:2 equal to 11 select an arithmetic right shift. When open, it fills with (N status OR carry-in). When closed, it behaves exactly like the closed logical right shift, so the N status bit has no effect.
- R6: With `byte_mode` = 1, the shifted field is bits 7:0 and its top is bit 7. Result bits 15:8 equal A bits 15:8.
- R7: Code bit 1 = 1 with a left shift gives a double left shift. XR bit 15 enters field bit 0 of A. Carry-in (open) or A's outgoing field top bit (closed) enters XR bit 0. The rest of XR shifts left.
- R8: Code bit 1 = 1 with a right shift gives a double right shift. XR bit 0 enters the field top bit of A. The fill value of R4/R5 enters XR bit 15: carry-in, N OR carry-in, or A bit 0 when closed. The rest of XR shifts right.
- R9: For swap and left shifts, overflow is the field top bit of A XOR the bit below it. For single right shifts, overflow is the field top bit of A XOR the value inserted at the top. For double right shifts, overflow is XR bit 0 XOR the field top bit of A.
- R10: Zero is 1 when the result field is all zeros. Positive is 1 when the result field is nonzero and its top bit is 0. Negative is the result field top bit and low-bit is result bit 0, except for double right shifts. There, negative is the new XR bit 15 and low-bit is A bit 0.
- R11: With code bit 1 = 0, `xr_q` equals the XR input for every operation.
- R12: Outputs change only at a rising clock edge, one cycle after the inputs are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_in | input | 16 | A operand |
| xr_in | input | 16 | Extension register value |
| cin | input | 1 | Carry-in |
| n_stat | input | 1 | Negative status bit used by the arithmetic fill |
| spec | input | 4 | Shift code: [3:2] operation, [1] double, [0] closed |
| byte_mode | input | 1 | Operate on the low byte only |
| res_q | output | 16 | Registered result |
| xr_q | output | 16 | Registered new XR value |
| flag_c | output | 1 | Carry |
| flag_v | output | 1 | Overflow |
| flag_z | output | 1 | Zero |
| flag_n | output | 1 | Negative |
| flag_p | output | 1 | Positive |
| flag_d | output | 1 | Low-bit |

## Verification
The hardest case to reach is a double right shift in byte mode. Here the XR link enters at bit 7 rather than bit 15, and the negative flag comes from the new XR top bit, not from the result. Each bit of that case is made observable by choosing A and XR so that the linked bit, the fill bit and the result-field sign all differ. The closed arithmetic shift is applied with the N status and carry-in both set, which shows at the ports that neither of them is used.

// File: rtl/lws_pkg.sv
package lws_pkg;

    typedef enum logic [1:0] {
        OP_SWAP = 2'b00,
        OP_SHL  = 2'b01,
        OP_SHR  = 2'b10,
        OP_SAR  = 2'b11
    } shop_e;

    typedef struct packed {
        logic c;
        logic v;
        logic z;
        logic n;
        logic p;
        logic d;
    } flags_t;

endpackage

// File: rtl/lws_field_shift.sv
module lws_field_shift
    import lws_pkg::*;
#(
    parameter int W  = 16,
    parameter int XW = 16
) (
    input  logic [W-1:0]  fld,
    input  logic [XW-1:0] xr,
    input  shop_e         op,
    input  logic          dbl,
    input  logic          closed,
    input  logic          cin,
    input  logic          nst,
    output logic [W-1:0]  res,
    output logic [XW-1:0] xr_n,
    output logic          c_o,
    output logic          v_o,
    output logic          n_o,
    output logic          d_o
);
    localparam int HW = W / 2;

    logic top_b;
    logic nxt_b;
    logic lsb_b;
    logic fill_r;
    logic fill_l;
    logic ins_l;
    logic ins_r;

    always_comb begin
        top_b  = fld[W-1];
        nxt_b  = fld[W-2];
        lsb_b  = fld[0];
        // value entering the top on a right shift (A field when single, XR when double)
        fill_r = closed ? lsb_b : ((op == OP_SAR) ? (nst | cin) : cin);
        // value entering bit 0 on a left shift (A field when single, XR when double)
        fill_l = closed ? top_b : cin;
        ins_l  = dbl ? xr[XW-1] : fill_l;
        ins_r  = dbl ? xr[0] : fill_r;

        res  = fld;
        xr_n = xr;
        c_o  = top_b;
        v_o  = top_b ^ nxt_b;
        n_o  = 1'b0;
        d_o  = 1'b0;

        unique case (op)
            OP_SWAP: begin
                res = {fld[HW-1:0], fld[W-1:HW]};
                n_o = res[W-1];
                d_o = res[0];
            end
            OP_SHL: begin
                res = {fld[W-2:0], ins_l};
                if (dbl) xr_n = {xr[XW-2:0], fill_l};
                n_o = res[W-1];
                d_o = res[0];
            end
            default: begin
                res = {ins_r, fld[W-1:1]};
                if (dbl) xr_n = {fill_r, xr[XW-1:1]};
                c_o = lsb_b;
                v_o = top_b ^ ins_r;
                n_o = dbl ? xr_n[XW-1] : res[W-1];
                d_o = dbl ? lsb_b : res[0];
            end
        endcase
    end

endmodule

// File: rtl/lws_zero_pos.sv
module lws_zero_pos #(
    parameter int W = 16
) (
    input  logic [W-1:0] fld,
    output logic         z_o,
    output logic         p_o
);
    always_comb begin
        z_o = (fld == '0);
        p_o = !z_o && !fld[W-1];
    end

endmodule

// File: rtl/lws_unit.sv
module lws_unit
    import lws_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] xr_in,
    input  logic              cin,
    input  logic              n_stat,
    input  logic [3:0]        spec,
    input  logic              byte_mode,
    output logic [DATA_W-1:0] res_q,
    output logic [DATA_W-1:0] xr_q,
    output logic              flag_c,
    output logic              flag_v,
    output logic              flag_z,
    output logic              flag_n,
    output logic              flag_p,
    output logic              flag_d
);
    localparam int LANE_W = DATA_W / 2;
    localparam int NVAR   = 2;   // index 0: full word, index 1: low lane

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic [DATA_W-1:0] xr;
        flags_t            fl;
    } stage_t;

    shop_e op_w;
    assign op_w = shop_e'(spec[3:2]);

    logic [DATA_W-1:0] res_g [NVAR];
    logic [DATA_W-1:0] xr_g  [NVAR];
    logic [NVAR-1:0]   c_g, v_g, n_g, d_g, z_g, p_g;

    for (genvar g = 0; g < NVAR; g++) begin : g_var
        localparam int W = (g == 0) ? DATA_W : LANE_W;
        logic [W-1:0] r_w;

        lws_field_shift #(.W(W), .XW(DATA_W)) u_shift (
            .fld    (a_in[W-1:0]),
            .xr     (xr_in),
            .op     (op_w),
            .dbl    (spec[1]),
            .closed (spec[0]),
            .cin    (cin),
            .nst    (n_stat),
            .res    (r_w),
            .xr_n   (xr_g[g]),
            .c_o    (c_g[g]),
            .v_o    (v_g[g]),
            .n_o    (n_g[g]),
            .d_o    (d_g[g])
        );

        lws_zero_pos #(.W(W)) u_zp (
            .fld (r_w),
            .z_o (z_g[g]),
            .p_o (p_g[g])
        );

        assign res_g[g] = DATA_W'(r_w);
    end

    stage_t stage_d;
    stage_t stage_q;
    int     sel;

    always_comb begin
        sel        = byte_mode ? 1 : 0;
        stage_d.res = res_g[sel];
        if (byte_mode) stage_d.res[DATA_W-1:LANE_W] = a_in[DATA_W-1:LANE_W];
        stage_d.xr   = xr_g[sel];
        stage_d.fl.c = c_g[sel];
        stage_d.fl.v = v_g[sel];
        stage_d.fl.z = z_g[sel];
        stage_d.fl.n = n_g[sel];
        stage_d.fl.p = p_g[sel];
        stage_d.fl.d = d_g[sel];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign res_q  = stage_q.res;
    assign xr_q   = stage_q.xr;
    assign flag_c = stage_q.fl.c;
    assign flag_v = stage_q.fl.v;
    assign flag_z = stage_q.fl.z;
    assign flag_n = stage_q.fl.n;
    assign flag_p = stage_q.fl.p;
    assign flag_d = stage_q.fl.d;

    p_swap_keeps_xr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(spec[3:2]) == 2'b00) |-> xr_q == $past(xr_in));

    p_right_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(spec[3])) |-> flag_c == $past(a_in[0]));

    p_high_lane_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(byte_mode))
            |-> res_q[DATA_W-1:LANE_W] == $past(a_in[DATA_W-1:LANE_W]));

    p_dbl_left_link_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(spec[3:1]) == 3'b011)
            |-> res_q[0] == $past(xr_in[DATA_W-1]));

    p_zero_not_pos_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flag_z |-> !flag_p);

    p_single_keeps_xr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(spec[1])) |-> xr_q == $past(xr_in));

endmodule

// File: tb/tb_lws_unit.sv
module tb_lws_unit;

    typedef struct packed {
        logic [3:0]  spec;
        logic        bm;
        logic        cin;
        logic        nst;
        logic [15:0] a;
        logic [15:0] xr;
        logic [15:0] er;
        logic [15:0] ex;
        logic [5:0]  ef;   // {c,v,z,n,p,d}
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{4'b0000, 1'b0, 1'b0, 1'b0, 16'h12F0, 16'hAAAA, 16'hF012, 16'hAAAA, 6'b000100}, // R2 word swap
        '{4'b0000, 1'b1, 1'b0, 1'b0, 16'h12F0, 16'hAAAA, 16'h120F, 16'hAAAA, 6'b100011}, // R2 R6 byte swap
        '{4'b0100, 1'b0, 1'b1, 1'b0, 16'h8001, 16'h1234, 16'h0003, 16'h1234, 6'b110011}, // R3 R9 R11 open left
        '{4'b0101, 1'b1, 1'b0, 1'b0, 16'h55C0, 16'h1234, 16'h5581, 16'h1234, 6'b100101}, // R3 R6 closed left byte
        '{4'b1000, 1'b0, 1'b0, 1'b0, 16'h0001, 16'h1234, 16'h0000, 16'h1234, 6'b101000}, // R4 R10 open right to zero
        '{4'b1100, 1'b0, 1'b0, 1'b1, 16'h4002, 16'h1234, 16'hA001, 16'h1234, 6'b010101}, // R5 R9 arith fill N
        '{4'b1101, 1'b1, 1'b1, 1'b1, 16'hFF02, 16'h1234, 16'hFF01, 16'h1234, 6'b000011}, // R5 R6 closed arith ignores N
        '{4'b0110, 1'b0, 1'b1, 1'b0, 16'h4000, 16'h8000, 16'h8001, 16'h0001, 6'b010101}, // R7 double open left
        '{4'b0111, 1'b1, 1'b0, 1'b0, 16'h3480, 16'h0000, 16'h3400, 16'h0001, 6'b111000}, // R7 R6 double closed left byte
        '{4'b1010, 1'b0, 1'b1, 1'b0, 16'h0003, 16'h0001, 16'h8001, 16'h8000, 6'b110101}, // R8 R9 R10 double open right
        '{4'b1110, 1'b1, 1'b0, 1'b1, 16'h7F10, 16'h0002, 16'h7F08, 16'h8001, 6'b000110}, // R8 R10 double arith byte
        '{4'b1011, 1'b0, 1'b0, 1'b0, 16'h0001, 16'h0000, 16'h0000, 16'h8000, 6'b101101}, // R8 double closed right
        '{4'b0010, 1'b0, 1'b0, 1'b0, 16'hABCD, 16'h5555, 16'hCDAB, 16'h5555, 6'b110101}  // R2 double swap keeps XR
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] a_in = '0;
    logic [15:0] xr_in = '0;
    logic        cin = 1'b0;
    logic        n_stat = 1'b0;
    logic [3:0]  spec = '0;
    logic        byte_mode = 1'b0;
    logic [15:0] res_q, xr_q;
    logic        flag_c, flag_v, flag_z, flag_n, flag_p, flag_d;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;   // 50 MHz

    lws_unit dut (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .xr_in(xr_in), .cin(cin),
        .n_stat(n_stat), .spec(spec), .byte_mode(byte_mode),
        .res_q(res_q), .xr_q(xr_q), .flag_c(flag_c), .flag_v(flag_v),
        .flag_z(flag_z), .flag_n(flag_n), .flag_p(flag_p), .flag_d(flag_d)
    );

    function automatic logic [5:0] flags();
        return {flag_c, flag_v, flag_z, flag_n, flag_p, flag_d};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        spec = v.spec; byte_mode = v.bm; cin = v.cin; n_stat = v.nst;
        a_in = v.a; xr_in = v.xr;
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset state, with busy inputs present
        a_in = 16'hFFFF; xr_in = 16'hFFFF; cin = 1'b1; spec = 4'b0110;
        repeat (3) @(negedge clk);
        check("R1 reset result/xr", {res_q, xr_q}, 32'h0);
        check("R1 reset flags", {26'h0, flags()}, 32'h0);
        rst_n = 1'b1;

        // table walk: each vector is loaded at a negedge and sampled one negedge later
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            apply(VECS[i]);
            @(negedge clk);
            check($sformatf("table %0d result", i), {16'h0, res_q}, {16'h0, VECS[i].er});
            check($sformatf("table %0d xr", i), {16'h0, xr_q}, {16'h0, VECS[i].ex});
            check($sformatf("table %0d flags", i), {26'h0, flags()}, {26'h0, VECS[i].ef});
        end

        // R12: new inputs do not reach the outputs before the next rising edge
        apply(VECS[0]);
        #2;
        check("R12 hold before edge", {16'h0, res_q}, {16'h0, VECS[NV-1].er});
        @(negedge clk);
        check("R12 update after edge", {16'h0, res_q}, {16'h0, VECS[0].er});

        // R5: open arithmetic fill from carry-in alone, N clear
        spec = 4'b1100; byte_mode = 1'b0; n_stat = 1'b0; cin = 1'b1; a_in = 16'h0004;
        @(negedge clk);
        check("R5 fill from cin", {16'h0, res_q}, 32'h0000_8002);

        // R1: reset applied mid-run clears everything
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-run reset result/xr", {res_q, xr_q}, 32'h0);
        check("R1 mid-run reset flags", {26'h0, flags()}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule